// File: doc/BRIEF.md
# System Instruction Trap Checker

This block decides, for one specific system instruction, what the core should do with an access request. It looks at the five encoding fields of the access, at the exception level the core is running at, and at a set of hypervisor trap controls. It then reports one of four outcomes: the encoding is not this instruction, the access is undefined, the access traps to the hypervisor level with an exception class, or the access executes.

The recognised encoding is the TLB invalidate by address-space identifier, inner-shareable, level 1 form. A request is captured on a strobe, and the verdict appears on the next cycle with a one-cycle valid pulse. The block only judges the request. Exception entry, register reads and the invalidation itself belong to other units.

Top module: `sys_insn_trap_unit`

## Requirements
- R1: A request matches only when op0=2'b01, op1=3'b000, crn=4'b1000, crm=4'b0011 and op2=3'b010. Any other request gives rsp_code 2'b00 (no match) and rsp_class 0, whatever the level and the controls.
- R2: A matching request at level 0 (cur_el=2'b00) gives rsp_code 2'b01 (undefined).
- R3: A matching request at level 1 (cur_el=2'b01) with hyp_enabled=1 and trap_all_tlb=1 gives rsp_code 2'b10 (trap) and rsp_class 6'h18. This check has the highest trap priority.
- R4: A matching request at level 1 with hyp_enabled=1, trap_all_tlb=0 and trap_tlb_is=1 gives a trap with class 6'h18.
- R5: A matching request at level 1 with hyp_enabled=1 and both earlier controls clear traps with class 6'h18 when fgt_insn_trap=1. This check counts only when el3_present=0 or fgt_allowed=1. When el3_present=1 and fgt_allowed=0, fgt_insn_trap has no effect.
- R6: A matching request at level 1 that hits no trap gives rsp_code 2'b11 (execute). When hyp_enabled=0, all three trap controls are ignored.
- R7: A matching request at level 2 or 3 (cur_el=2'b10 or 2'b11) always gives rsp_code 2'b11, whatever the trap controls are.
- R8: rsp_class is zero whenever rsp_code is not 2'b10.
- R9: rsp_valid pulses in the cycle after each clock edge that samples req_valid=1, and is low otherwise. While rsp_valid is low, rsp_code and rsp_class read zero.
- R10: After a synchronous reset, rsp_valid, rsp_code and rsp_class are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe. The other inputs are sampled when it is high |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| hyp_enabled | input | 1 | Hypervisor level is enabled |
| trap_all_tlb | input | 1 | Trap all TLB maintenance to level 2 |
| trap_tlb_is | input | 1 | Trap inner-shareable TLB maintenance to level 2 |
| fgt_insn_trap | input | 1 | Fine-grained trap bit for this instruction |
| el3_present | input | 1 | Level 3 is implemented |
| fgt_allowed | input | 1 | Level 3 permits fine-grained traps |
| rsp_valid | output | 1 | One-cycle verdict strobe |
| rsp_code | output | 2 | 00 no match, 01 undefined, 10 trap, 11 execute |
| rsp_class | output | 6 | Exception class. It is 6'h18 on a trap and zero otherwise |

## Verification
Each verdict belongs to the clock edge that samples the request strobe. The bench drives inputs on the falling edge, lets one rising edge capture them, and reads rsp_valid, rsp_code and rsp_class at the next falling edge. A request with its strobe dropped is followed by an idle read one cycle later, which checks that the pulse lasts one cycle and that the outputs return to zero. Back-to-back requests are also issued, so that each result is checked exactly one edge after its own stimulus and never against the request before it.

// File: rtl/sys_insn_trap_pkg.sv
package sys_insn_trap_pkg;

    localparam int OP0_W   = 2;
    localparam int OP1_W   = 3;
    localparam int CRN_W   = 4;
    localparam int CRM_W   = 4;
    localparam int OP2_W   = 3;
    localparam int EL_W    = 2;
    localparam int CLASS_W = 6;
    localparam int NUM_TRAP_SRC = 3;

    typedef enum logic [1:0] {
        RES_NOMATCH = 2'b00,
        RES_UNDEF   = 2'b01,
        RES_TRAP    = 2'b10,
        RES_EXEC    = 2'b11
    } res_code_e;

    typedef enum logic [EL_W-1:0] {
        LVL_USER  = 2'd0,
        LVL_KERN  = 2'd1,
        LVL_HYP   = 2'd2,
        LVL_MON   = 2'd3
    } level_e;

    typedef struct packed {
        logic [OP0_W-1:0] op0;
        logic [OP1_W-1:0] op1;
        logic [CRN_W-1:0] crn;
        logic [CRM_W-1:0] crm;
        logic [OP2_W-1:0] op2;
    } enc_t;

    typedef struct packed {
        level_e level;
        logic   hyp_on;
        logic   all_tlb;
        logic   tlb_is;
        logic   fg_bit;
        logic   top_lvl_present;
        logic   fg_permit;
    } ctl_t;

    typedef struct packed {
        res_code_e          code;
        logic [CLASS_W-1:0] ec;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{code: RES_NOMATCH, ec: '0};

    // Fine-grained controls only count when the top level cannot veto them.
    function automatic logic fg_effective(input ctl_t c);
        return c.fg_bit & (~c.top_lvl_present | c.fg_permit);
    endfunction

    function automatic verdict_t make_verdict(input res_code_e code,
                                              input logic [CLASS_W-1:0] trap_ec);
        verdict_t v;
        v.code = code;
        v.ec   = (code == RES_TRAP) ? trap_ec : '0;
        return v;
    endfunction

endpackage

// File: rtl/sys_insn_enc_match.sv
module sys_insn_enc_match
    import sys_insn_trap_pkg::*;
#(
    parameter logic [OP0_W-1:0] M_OP0 = 2'b01,
    parameter logic [OP1_W-1:0] M_OP1 = 3'b000,
    parameter logic [CRN_W-1:0] M_CRN = 4'b1000,
    parameter logic [CRM_W-1:0] M_CRM = 4'b0011,
    parameter logic [OP2_W-1:0] M_OP2 = 3'b010
) (
    input  enc_t enc,
    output logic hit
);
    localparam int NFIELD = 5;
    logic [NFIELD-1:0] field_eq;

    always_comb begin
        field_eq[0] = (enc.op0 == M_OP0);
        field_eq[1] = (enc.op1 == M_OP1);
        field_eq[2] = (enc.crn == M_CRN);
        field_eq[3] = (enc.crm == M_CRM);
        field_eq[4] = (enc.op2 == M_OP2);
    end

    assign hit = &field_eq;
endmodule

// File: rtl/sys_insn_trap_resolve.sv
module sys_insn_trap_resolve
    import sys_insn_trap_pkg::*;
#(
    parameter logic [CLASS_W-1:0] TRAP_EC = 6'h18
) (
    input  logic     hit,
    input  ctl_t     ctl,
    output verdict_t verdict
);
    logic [NUM_TRAP_SRC-1:0] src;
    logic [NUM_TRAP_SRC-1:0] granted;
    logic                    any_trap;

    // Source 0 has the highest priority, source 2 the lowest.
    always_comb begin
        src[0] = ctl.hyp_on & ctl.all_tlb;
        src[1] = ctl.hyp_on & ctl.tlb_is;
        src[2] = ctl.hyp_on & fg_effective(ctl);
    end

    generate
        for (genvar i = 0; i < NUM_TRAP_SRC; i++) begin : g_prio
            if (i == 0) begin : g_first
                assign granted[i] = src[i];
            end else begin : g_rest
                assign granted[i] = src[i] & ~|src[i-1:0];
            end
        end
    endgenerate

    assign any_trap = |granted;

    always_comb begin
        res_code_e code;
        if (!hit) begin
            code = RES_NOMATCH;
        end else begin
            unique case (ctl.level)
                LVL_USER: code = RES_UNDEF;
                LVL_KERN: code = any_trap ? RES_TRAP : RES_EXEC;
                default:  code = RES_EXEC;
            endcase
        end
        verdict = make_verdict(code, TRAP_EC);
    end
endmodule

// File: rtl/sys_insn_result_reg.sv
module sys_insn_result_reg
    import sys_insn_trap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  verdict_t nxt,
    output logic     out_valid,
    output verdict_t out_verdict
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_verdict <= VERDICT_IDLE;
        end else begin
            out_valid   <= take;
            out_verdict <= take ? nxt : VERDICT_IDLE;
        end
    end
endmodule

// File: rtl/sys_insn_trap_unit.sv
module sys_insn_trap_unit
    import sys_insn_trap_pkg::*;
#(
    parameter logic [OP0_W-1:0]   M_OP0   = 2'b01,
    parameter logic [OP1_W-1:0]   M_OP1   = 3'b000,
    parameter logic [CRN_W-1:0]   M_CRN   = 4'b1000,
    parameter logic [CRM_W-1:0]   M_CRM   = 4'b0011,
    parameter logic [OP2_W-1:0]   M_OP2   = 3'b010,
    parameter logic [CLASS_W-1:0] TRAP_EC = 6'h18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [OP0_W-1:0]   op0,
    input  logic [OP1_W-1:0]   op1,
    input  logic [CRN_W-1:0]   crn,
    input  logic [CRM_W-1:0]   crm,
    input  logic [OP2_W-1:0]   op2,
    input  logic [EL_W-1:0]    cur_el,
    input  logic               hyp_enabled,
    input  logic               trap_all_tlb,
    input  logic               trap_tlb_is,
    input  logic               fgt_insn_trap,
    input  logic               el3_present,
    input  logic               fgt_allowed,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic [CLASS_W-1:0] rsp_class
);
    enc_t     enc;
    ctl_t     ctl;
    logic     hit;
    verdict_t nxt_verdict;
    verdict_t cur_verdict;

    always_comb begin
        enc.op0 = op0;
        enc.op1 = op1;
        enc.crn = crn;
        enc.crm = crm;
        enc.op2 = op2;
        ctl.level           = level_e'(cur_el);
        ctl.hyp_on          = hyp_enabled;
        ctl.all_tlb         = trap_all_tlb;
        ctl.tlb_is          = trap_tlb_is;
        ctl.fg_bit          = fgt_insn_trap;
        ctl.top_lvl_present = el3_present;
        ctl.fg_permit       = fgt_allowed;
    end

    sys_insn_enc_match #(
        .M_OP0(M_OP0), .M_OP1(M_OP1), .M_CRN(M_CRN),
        .M_CRM(M_CRM), .M_OP2(M_OP2)
    ) u_match (
        .enc (enc),
        .hit (hit)
    );

    sys_insn_trap_resolve #(.TRAP_EC(TRAP_EC)) u_resolve (
        .hit     (hit),
        .ctl     (ctl),
        .verdict (nxt_verdict)
    );

    sys_insn_result_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .take        (req_valid),
        .nxt         (nxt_verdict),
        .out_valid   (rsp_valid),
        .out_verdict (cur_verdict)
    );

    assign rsp_code  = cur_verdict.code;
    assign rsp_class = cur_verdict.ec;
endmodule

// File: rtl/sys_insn_trap_unit_props.sv
module sys_insn_trap_unit_props (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] op0,
    input logic [2:0] op1,
    input logic [3:0] crn,
    input logic [3:0] crm,
    input logic [2:0] op2,
    input logic [1:0] cur_el,
    input logic       hyp_enabled,
    input logic       trap_all_tlb,
    input logic       trap_tlb_is,
    input logic       fgt_insn_trap,
    input logic       el3_present,
    input logic       fgt_allowed,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic [5:0] rsp_class
);
    logic is_target;
    assign is_target = (op0 == 2'b01) && (op1 == 3'b000) && (crn == 4'b1000)
                    && (crm == 4'b0011) && (op2 == 3'b010);

    assert_pulse_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_code == 2'b00 && rsp_class == 6'h00));
    assert_class_only_on_trap_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_code != 2'b10) |-> (rsp_class == 6'h00));
    assert_nomatch_code_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_target) |=> (rsp_code == 2'b00));
    assert_user_undef_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_target && cur_el == 2'b00) |=> (rsp_code == 2'b01));
    assert_all_tlb_trap_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_target && cur_el == 2'b01 && hyp_enabled && trap_all_tlb)
        |=> (rsp_code == 2'b10 && rsp_class == 6'h18));
    assert_no_hyp_exec_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_target && cur_el == 2'b01 && !hyp_enabled)
        |=> (rsp_code == 2'b11));
    assert_high_level_exec_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_target && cur_el[1]) |=> (rsp_code == 2'b11));
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!rsp_valid && rsp_code == 2'b00 && rsp_class == 6'h00));
endmodule

bind sys_insn_trap_unit sys_insn_trap_unit_props u_props (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .cur_el(cur_el), .hyp_enabled(hyp_enabled),
    .trap_all_tlb(trap_all_tlb), .trap_tlb_is(trap_tlb_is),
    .fgt_insn_trap(fgt_insn_trap), .el3_present(el3_present),
    .fgt_allowed(fgt_allowed), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_class(rsp_class)
);

// File: tb/sys_insn_trap_unit_test.sv
`timescale 1ns/1ps
module sys_insn_trap_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] op0 = '0;
    logic [2:0] op1 = '0;
    logic [3:0] crn = '0;
    logic [3:0] crm = '0;
    logic [2:0] op2 = '0;
    logic [1:0] cur_el = '0;
    logic hyp_enabled = 1'b0, trap_all_tlb = 1'b0, trap_tlb_is = 1'b0;
    logic fgt_insn_trap = 1'b0, el3_present = 1'b0, fgt_allowed = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_code;
    logic [5:0] rsp_class;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sys_insn_trap_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
        .cur_el(cur_el), .hyp_enabled(hyp_enabled),
        .trap_all_tlb(trap_all_tlb), .trap_tlb_is(trap_tlb_is),
        .fgt_insn_trap(fgt_insn_trap), .el3_present(el3_present),
        .fgt_allowed(fgt_allowed), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_class(rsp_class)
    );

    // Expected {code, class} from the requirements
    function automatic logic [7:0] model(input logic [1:0] o0, input logic [2:0] o1,
                                         input logic [3:0] cn, input logic [3:0] cm,
                                         input logic [2:0] o2, input logic [1:0] el,
                                         input logic hy, input logic ta, input logic ti,
                                         input logic fb, input logic e3, input logic fa);
        bit m;
        m = (o0 == 2'b01) && (o1 == 3'b000) && (cn == 4'b1000) && (cm == 4'b0011) && (o2 == 3'b010);
        if (!m) return {2'b00, 6'h00};
        if (el == 2'd0) return {2'b01, 6'h00};
        if (el == 2'd1) begin
            if (hy && (ta || ti || (fb && (!e3 || fa)))) return {2'b10, 6'h18};
            return {2'b11, 6'h00};
        end
        return {2'b11, 6'h00};
    endfunction

    function automatic string tag_of(input logic [7:0] e, input logic [1:0] el);
        if (e[7:6] == 2'b00) return "R1";
        if (e[7:6] == 2'b01) return "R2";
        if (e[7:6] == 2'b10) return "R4";
        if (el >= 2'd2) return "R7";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic v, input logic [1:0] c,
                         input logic [5:0] k);
        checks++;
        if (rsp_valid !== v || rsp_code !== c || rsp_class !== k) begin
            failures++;
            $display("FAIL %s: got valid=%0b code=%b class=%h, expected valid=%0b code=%b class=%h",
                     tag, rsp_valid, rsp_code, rsp_class, v, c, k);
        end
    endtask

    task automatic set_ctl(input logic [1:0] el, input logic hy, input logic ta,
                           input logic ti, input logic fb, input logic e3, input logic fa);
        cur_el = el; hyp_enabled = hy; trap_all_tlb = ta; trap_tlb_is = ti;
        fgt_insn_trap = fb; el3_present = e3; fgt_allowed = fa;
    endtask

    task automatic set_target();
        op0 = 2'b01; op1 = 3'b000; crn = 4'b1000; crm = 4'b0011; op2 = 3'b010;
    endtask

    // Request driven at negedge, captured at next posedge, read at the following negedge.
    task automatic issue(input string tag, input bit keep);
        logic [7:0] e;
        e = model(op0, op1, crn, crm, op2, cur_el, hyp_enabled, trap_all_tlb,
                  trap_tlb_is, fgt_insn_trap, el3_present, fgt_allowed);
        req_valid = 1'b1;
        @(negedge clk);
        check(tag, 1'b1, e[7:6], e[5:0]);
        if (!keep) req_valid = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        req_valid = 1'b0;
        op0 = 2'b01; set_ctl(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check(tag, 1'b0, 2'b00, 6'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'hC0FFEE);
        repeat (3) @(negedge clk);
        check("R10", 1'b0, 2'b00, 6'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R10", 1'b0, 2'b00, 6'h00);

        // R2: user level undefined, even with all traps set
        set_target(); set_ctl(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        issue("R2", 1'b0);
        idle_check("R9");
        // R3: trap-all has top priority
        set_target(); set_ctl(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        issue("R3", 1'b0);
        idle_check("R9");
        // R4: inner-shareable trap alone
        set_target(); set_ctl(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        issue("R4", 1'b0);
        // R5: fine-grained, no top level
        set_target(); set_ctl(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        issue("R5", 1'b0);
        // R5: fine-grained, top level permits
        set_ctl(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        issue("R5", 1'b0);
        // R5: fine-grained vetoed -> executes
        set_ctl(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        issue("R5", 1'b0);
        // R6: hypervisor off ignores every trap control
        set_ctl(2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        issue("R6", 1'b0);
        set_ctl(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        issue("R6", 1'b0);
        // R7: levels 2 and 3, back to back
        set_ctl(2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        issue("R7", 1'b1);
        set_ctl(2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        issue("R7", 1'b0);
        idle_check("R9");
        // R1: one field off at a time, trap conditions set
        for (int f = 0; f < 5; f++) begin
            set_target(); set_ctl(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
            case (f)
                0: op0 = 2'b11;
                1: op1 = 3'b001;
                2: crn = 4'b1001;
                3: crm = 4'b0111;
                default: op2 = 3'b011;
            endcase
            issue("R1", 1'b1);
        end
        req_valid = 1'b0;
        // R8: class zero for every non-trap code, checked through mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] e;
            bit keep;
            if ($urandom_range(1, 0) == 1) set_target();
            else begin
                op0 = 2'($urandom); op1 = 3'($urandom); crn = 4'($urandom);
                crm = 4'($urandom); op2 = 3'($urandom);
            end
            set_ctl(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom));
            e = model(op0, op1, crn, crm, op2, cur_el, hyp_enabled, trap_all_tlb,
                      trap_tlb_is, fgt_insn_trap, el3_present, fgt_allowed);
            keep = ($urandom_range(3, 0) != 0);
            issue(tag_of(e, cur_el), keep);
            if (e[7:6] != 2'b10 && rsp_class !== 6'h00) begin
                failures++;
                $display("FAIL R8: got class=%h, expected class=00", rsp_class);
            end
            checks++;
            if (!keep) idle_check("R9");
        end

        // R10: reset mid-stream clears a pending result
        set_target(); set_ctl(2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        req_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        check("R10", 1'b0, 2'b00, 6'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule